// File: doc/BRIEF.md
# Receive Descriptor-Chain DMA Sequencer

This block moves received frames from a byte-wide MAC receive FIFO into system memory by following a linked chain of four-word descriptors. Each descriptor holds a buffer pointer with an ownership flag in its top bit, a control word that is not used here, a status-and-length word, and the address of the next descriptor. When a frame starts, the sequencer reads the pointer word. If the engine owns the descriptor, the sequencer packs the frame bytes into 32-bit words and writes them to the buffer. It then writes the status-and-length word, hands the descriptor back by rewriting the pointer word with bit 31 clear, and reads the link to the next descriptor.

Memory is reached through a word-wide request/acknowledge port. A request stays up until it is acknowledged, and read data is valid in the acknowledge cycle. Software-facing controls are plain inputs:
- enable and software reset;
- the stop-or-skip policy for descriptors the engine does not own;
- buffer address direction;
- byte order;
- a two-bit count of invalid leading bytes;
- one interrupt enable per event.

The states are IDLE, ARM, RD_OWN, COLLECT, WR_DATA, WR_STAT, WR_OWN, RD_NEXT, DROP and HALT. The transitions are:
- IDLE goes to ARM when enabled, and takes the start descriptor address.
- ARM goes to RD_OWN when a frame byte is offered.
- RD_OWN goes to COLLECT if the descriptor is owned. If it is not owned, RD_OWN goes to HALT under the stop policy or to DROP under the skip policy.
- COLLECT goes to WR_DATA when a word is full or the frame ends. It goes straight to WR_STAT if the frame ends with nothing left to write.
- WR_DATA goes back to COLLECT, or to WR_STAT after the last word.
- WR_STAT goes to WR_OWN, and WR_OWN goes to RD_NEXT.
- RD_NEXT goes to ARM on a non-zero link, or to HALT on a zero link.
- DROP goes to ARM at the end of the dropped frame.
- Software reset forces IDLE from any state.

Top module: `rxdesc_dma_seq`

## Requirements
- R1: When a frame's first byte is offered, the engine reads the word at the current descriptor address. Bit 31 of that word is the ownership flag (1 = engine, 0 = CPU). The buffer base is that word with bits 31, 1 and 0 forced to zero.
- R2: Frame bytes are placed into 32-bit words starting at lane `cfg_align` (0..3). Lanes before it are written as zero. With `cfg_little`=1, lane k occupies bits 8k+7..8k; with `cfg_little`=0 it occupies bits 31-8k..24-8k. A word is written when lane 3 is filled or at the frame's last stored byte, and unfilled trailing lanes read as zero.
- R3: Successive data words go to the buffer base, then base+4, base+8 and so on when `cfg_addr_dec`=0, or base-4, base-8 and so on when `cfg_addr_dec`=1.
- R4: After the last data word, the engine performs three accesses in order. It writes descriptor+8 with {frame status[15:0] captured at the last byte, stored byte count[15:0]}. It then writes descriptor+0 with the pointer word read earlier, with bit 31 cleared. Finally it reads descriptor+12 as the next descriptor address.
- R5: Completing a frame hand-back sets sticky `sts[0]`, and pulses `irq[0]` for one cycle only if `cfg_irq_en[0]` is set.
- R6: A zero next-descriptor address sets sticky `sts[1]` (with an `irq[1]` pulse if `cfg_irq_en[1]`). The engine then halts, and `rx_ready` stays low and no memory access is made until software reset.
- R7: A descriptor read with bit 31 = 0 sets sticky `sts[2]` (with an `irq[2]` pulse if `cfg_irq_en[2]`). With `cfg_skip`=0 the engine halts without consuming the frame. With `cfg_skip`=1 the frame is consumed with no memory writes, and ownership is read again when the next frame starts.
- R8: Bytes beyond 1520 (`MAX_LEN`) in a frame are consumed but not stored. The length field then reads 1520, and sticky `sts[3]` is set (with an `irq[3]` pulse if `cfg_irq_en[3]`).
- R9: While `cfg_enable` is low after reset, no memory request is made and `rx_ready` stays low. The first descriptor fetched after enabling is at `start_desc`.
- R10: Reset, or a cycle with `cfg_soft_rst` high, clears `sts`, returns the engine to idle and leaves `mem_req` and `rx_ready` low in the following cycle.
- R11: Once raised, `mem_req` stays high, and `mem_addr`, `mem_we` and `mem_wdata` stay stable, until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Allows leaving idle and fetching from `start_desc` |
| cfg_soft_rst | input | 1 | Synchronous return to idle, clears sticky status |
| cfg_skip | input | 1 | 1 = drop frames on a CPU-owned descriptor, 0 = halt |
| cfg_addr_dec | input | 1 | 1 = buffer address steps down by 4 |
| cfg_little | input | 1 | 1 = little-endian byte lanes |
| cfg_align | input | 2 | Number of invalid leading bytes in the first word |
| cfg_irq_en | input | 4 | Interrupt enables: done, null, not-owner, oversize |
| start_desc | input | 32 | First descriptor address |
| rx_valid | input | 1 | FIFO byte available |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| rx_byte | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_stat | input | 16 | Frame status, sampled with the last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| sts | output | 4 | Sticky flags: done, null, not-owner, oversize |
| irq | output | 4 | One-cycle interrupt pulses, same bit order |

## Verification
The bench checks every memory write in the order the design issues it. This catches a design that writes status before the last data word, or hands a descriptor back before status is written. It exercises several alignments:
- An offset of three with big-endian packing and a decrementing buffer, so a wrong lane mapping or a wrong step direction shows up as wrong data or wrong addresses.
- A 1521-byte frame, where a design that stores the extra byte, or writes a spurious empty trailing word, fails the comparison.

A CPU-owned descriptor is tried under both policies. Under the skip policy, any write during the dropped frame is flagged. If the design does not re-read ownership on the following frame, the expected writes never appear. A masked done interrupt and the halted state after a zero link are also observed at the ports.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM,
        S_RD_OWN,
        S_COLLECT,
        S_WR_DATA,
        S_WR_STAT,
        S_WR_OWN,
        S_RD_NEXT,
        S_DROP,
        S_HALT
    } seq_state_t;

    localparam int NUM_FLAGS = 4;
    localparam int F_DONE    = 0;
    localparam int F_NULL    = 1;
    localparam int F_NOTOWN  = 2;
    localparam int F_MAXSZ   = 3;

    localparam int OWN_BIT   = 31;

endpackage

// File: rtl/rxdma_packer.sv
module rxdma_packer #(
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      init,
    input  logic [$clog2(LANES)-1:0]  align,
    input  logic                      put,
    input  logic                      little,
    input  logic [7:0]                din,
    input  logic                      clr,
    output logic [8*LANES-1:0]        word,
    output logic [$clog2(LANES)-1:0]  lane,
    output logic                      has
);
    localparam int LW = $clog2(LANES);
    localparam int WW = 8 * LANES;

    logic [WW-1:0] word_nx;
    int            pos;

    always_comb begin
        pos     = little ? int'(lane) : (LANES - 1 - int'(lane));
        word_nx = word;
        word_nx[8*pos +: 8] = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            lane <= '0;
            has  <= 1'b0;
        end else if (init) begin
            word <= '0;
            lane <= align;
            has  <= 1'b0;
        end else if (clr) begin
            word <= '0;
            has  <= 1'b0;
        end else if (put) begin
            word <= word_nx;
            lane <= lane + LW'(1);
            has  <= 1'b1;
        end
    end

endmodule

// File: rtl/rxdma_bufaddr.sv
module rxdma_bufaddr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    input  logic          dec,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] INC = AW'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (step)
            addr <= dec ? (addr - INC) : (addr + INC);
    end

endmodule

// File: rtl/rxdma_flags.sv
module rxdma_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] ie,
    output logic [N-1:0] sts,
    output logic [N-1:0] irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
            irq <= '0;
        end else if (clr) begin
            sts <= '0;
            irq <= '0;
        end else begin
            sts <= sts | ev;
            irq <= ev & ie;
        end
    end

    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~sts) == '0); // R5

endmodule

// File: rtl/rxdesc_dma_seq.sv
module rxdesc_dma_seq #(
    parameter int MAX_LEN = 1520,
    parameter int LEN_W   = 16,
    parameter int STAT_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_enable,
    input  logic        cfg_soft_rst,
    input  logic        cfg_skip,
    input  logic        cfg_addr_dec,
    input  logic        cfg_little,
    input  logic [1:0]  cfg_align,
    input  logic [3:0]  cfg_irq_en,
    input  logic [31:0] start_desc,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_byte,
    input  logic        rx_last,
    input  logic [15:0] rx_stat,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic [3:0]  sts,
    output logic [3:0]  irq
);
    import rxdma_pkg::*;

    localparam int                 AW       = 32;
    localparam int                 LANES    = 4;
    localparam logic [AW-1:0]      OFS_STAT = AW'(8);
    localparam logic [AW-1:0]      OFS_NEXT = AW'(12);
    localparam logic [LEN_W-1:0]   LEN_CAP  = LEN_W'(MAX_LEN);

    seq_state_t st, st_nx;

    logic [AW-1:0]          cur_desc;
    logic [AW-1:0]          own_q;
    logic [LEN_W-1:0]       len_q;
    logic                   over_q;
    logic                   last_q;
    logic [STAT_W-1:0]      stat_q;

    logic [NUM_FLAGS-1:0]   ev;
    logic [AW-1:0]          pk_word;
    logic [1:0]             pk_lane;
    logic                   pk_has;
    logic                   pk_init, pk_put, pk_clr;
    logic                   ba_load, ba_step;
    logic [AW-1:0]          ba_base;
    logic [AW-1:0]          buf_addr;
    logic                   rx_fire;
    logic                   store;
    logic                   owned;

    assign rx_fire = rx_valid && rx_ready;
    assign store   = rx_fire && (st == S_COLLECT) && (len_q < LEN_CAP);
    assign owned   = mem_rdata[OWN_BIT];
    assign ba_base = {1'b0, mem_rdata[AW-2:2], 2'b00};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= S_IDLE;
        else if (cfg_soft_rst)
            st <= S_IDLE;
        else
            st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (cfg_enable) st_nx = S_ARM;
            S_ARM:     if (rx_valid) st_nx = S_RD_OWN;
            S_RD_OWN:  if (mem_ack) begin
                           if (owned)         st_nx = S_COLLECT;
                           else if (cfg_skip) st_nx = S_DROP;
                           else               st_nx = S_HALT;
                       end
            S_COLLECT: if (rx_valid) begin
                           if (store) begin
                               if (pk_lane == 2'd3 || rx_last) st_nx = S_WR_DATA;
                           end else if (rx_last) begin
                               st_nx = pk_has ? S_WR_DATA : S_WR_STAT;
                           end
                       end
            S_WR_DATA: if (mem_ack) st_nx = last_q ? S_WR_STAT : S_COLLECT;
            S_WR_STAT: if (mem_ack) st_nx = S_WR_OWN;
            S_WR_OWN:  if (mem_ack) st_nx = S_RD_NEXT;
            S_RD_NEXT: if (mem_ack) st_nx = (mem_rdata == '0) ? S_HALT : S_ARM;
            S_DROP:    if (rx_valid && rx_last) st_nx = S_ARM;
            S_HALT:    st_nx = S_HALT;
            default:   st_nx = S_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        rx_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ev        = '0;
        pk_init   = 1'b0;
        pk_put    = store;
        pk_clr    = 1'b0;
        ba_load   = 1'b0;
        ba_step   = 1'b0;
        unique case (st)
            S_RD_OWN: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc;
                if (mem_ack) begin
                    ev[F_NOTOWN] = !owned;
                    pk_init      = owned;
                    ba_load      = owned;
                end
            end
            S_COLLECT: begin
                rx_ready = 1'b1;
                ev[F_MAXSZ] = rx_valid && (len_q == LEN_CAP) && !over_q;
            end
            S_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_addr;
                mem_wdata = pk_word;
                pk_clr    = mem_ack;
                ba_step   = mem_ack;
            end
            S_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_desc + OFS_STAT;
                mem_wdata = 32'({stat_q, len_q});
            end
            S_WR_OWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_desc;
                mem_wdata = own_q & ~(32'd1 << OWN_BIT);
                ev[F_DONE] = mem_ack;
            end
            S_RD_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc + OFS_NEXT;
                ev[F_NULL] = mem_ack && (mem_rdata == '0);
            end
            S_DROP:  rx_ready = 1'b1;
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_desc <= '0;
            own_q    <= '0;
            len_q    <= '0;
            over_q   <= 1'b0;
            last_q   <= 1'b0;
            stat_q   <= '0;
        end else if (!cfg_soft_rst) begin
            if (st == S_IDLE && cfg_enable)
                cur_desc <= start_desc;
            if (st == S_RD_OWN && mem_ack) begin
                own_q  <= mem_rdata;
                len_q  <= '0;
                over_q <= 1'b0;
                last_q <= 1'b0;
            end
            if (st == S_COLLECT && rx_fire) begin
                if (store)
                    len_q <= len_q + LEN_W'(1);
                else
                    over_q <= 1'b1;
                if (rx_last) begin
                    last_q <= 1'b1;
                    stat_q <= STAT_W'(rx_stat);
                end
            end
            if (st == S_RD_NEXT && mem_ack && mem_rdata != '0)
                cur_desc <= mem_rdata;
        end
    end

    rxdma_packer #(.LANES(LANES)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (pk_init),
        .align  (cfg_align),
        .put    (pk_put),
        .little (cfg_little),
        .din    (rx_byte),
        .clr    (pk_clr),
        .word   (pk_word),
        .lane   (pk_lane),
        .has    (pk_has)
    );

    rxdma_bufaddr #(.AW(AW), .STEP(LANES)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ba_load),
        .base  (ba_base),
        .step  (ba_step),
        .dec   (cfg_addr_dec),
        .addr  (buf_addr)
    );

    rxdma_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_soft_rst),
        .ev    (ev),
        .ie    (cfg_irq_en),
        .sts   (sts),
        .irq   (irq)
    );

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cfg_soft_rst) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

    AST_STAT_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && (mem_addr == cur_desc + OFS_STAT) && !cfg_soft_rst) |=>
        (mem_req && mem_we && (mem_addr == cur_desc) && !mem_wdata[OWN_BIT])); // R4

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_CAP); // R8

    AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_soft_rst |=> (sts == '0 && !mem_req && !rx_ready)); // R10

endmodule

// File: tb/rxdesc_dma_seq_test.sv
`timescale 1ns/1ps
module rxdesc_dma_seq_test;

    localparam int MAXL = 1520;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_soft_rst = 1'b0, cfg_skip = 1'b0;
    logic        cfg_addr_dec = 1'b0, cfg_little = 1'b1;
    logic [1:0]  cfg_align = 2'd0;
    logic [3:0]  cfg_irq_en = 4'hF;
    logic [31:0] start_desc = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_byte = '0;
    logic [15:0] rx_stat = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  sts, irq;

    logic [31:0] mem [0:4095];
    logic [63:0] exp_q [$];
    int          n_chk = 0, n_fail = 0;
    int          irq_cnt [4];

    always #4 clk = ~clk;

    rxdesc_dma_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_soft_rst(cfg_soft_rst),
        .cfg_skip(cfg_skip), .cfg_addr_dec(cfg_addr_dec), .cfg_little(cfg_little),
        .cfg_align(cfg_align), .cfg_irq_en(cfg_irq_en), .start_desc(start_desc),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte), .rx_last(rx_last),
        .rx_stat(rx_stat), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .sts(sts), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: acknowledge one cycle after a request is seen
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[13:2]];
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // monitor: compare every write against the scoreboard, count interrupts
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_we && mem_ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 R4 unexpected write", {mem_addr, mem_wdata}, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R2 R3 R4 write order/data", {mem_addr, mem_wdata}, e);
                end
            end
            for (int i = 0; i < 4; i++) if (irq[i]) irq_cnt[i]++;
        end
    end

    task automatic expect_frame(input logic [31:0] desc, input logic [31:0] w0, input int n,
                                input int align, input bit little, input bit dec,
                                input logic [7:0] seed, input logic [15:0] stat);
        int          stored, nw, p;
        logic [31:0] base, word, addr;
        stored = (n > MAXL) ? MAXL : n;
        nw     = (align + stored + 3) / 4;
        base   = {1'b0, w0[30:2], 2'b00};
        for (int w = 0; w < nw; w++) begin
            word = '0;
            for (int k = 0; k < 4; k++) begin
                p = w * 4 + k - align;
                if (p >= 0 && p < stored) begin
                    if (little) word[8*k +: 8] = seed + 8'(p);
                    else        word[8*(3-k) +: 8] = seed + 8'(p);
                end
            end
            addr = dec ? (base - 32'(4 * w)) : (base + 32'(4 * w));
            exp_q.push_back({addr, word});
        end
        exp_q.push_back({desc + 32'd8, stat, 16'(stored)});
        exp_q.push_back({desc, w0 & 32'h7FFF_FFFF});
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed, input logic [15:0] stat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = seed + 8'(i);
            rx_last  = (i == n - 1);
            rx_stat  = stat;
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic soft_reset();
        @(negedge clk);
        cfg_soft_rst = 1'b1;
        @(negedge clk);
        cfg_soft_rst = 1'b0;
    endtask

    task automatic offer_while_halted(input string tag);
        bit bad;
        bad = 1'b0;
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = 8'hEE;
        rx_last  = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (rx_ready || mem_req) bad = 1'b1;
        end
        chk(!bad, tag, {62'd0, rx_ready, mem_req}, 64'd0);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) irq_cnt[i] = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sts == 4'd0 && irq == 4'd0, "R10 reset flags", {56'd0, sts, irq}, 64'd0);
        chk(!mem_req && !rx_ready, "R10 reset idle", {62'd0, mem_req, rx_ready}, 64'd0);

        // R9: disabled engine ignores an offered byte
        offer_while_halted("R9 disabled engine stays quiet");

        // descriptor chain
        mem[32'h100 >> 2] = 32'h8000_1000; mem[(32'h100 >> 2) + 3] = 32'h110;
        mem[32'h110 >> 2] = 32'h8000_3000; mem[(32'h110 >> 2) + 3] = 32'h120;
        mem[32'h120 >> 2] = 32'h8000_2000; mem[(32'h120 >> 2) + 3] = 32'h0;
        start_desc = 32'h100;
        cfg_enable = 1'b1;

        // frame 1: R1 R2 R3 little-endian, offset 0, incrementing
        expect_frame(32'h100, 32'h8000_1000, 10, 0, 1'b1, 1'b0, 8'h10, 16'h4001);
        send_frame(10, 8'h10, 16'h4001);
        drain();
        chk(sts == 4'b0001, "R5 done flag", {60'd0, sts}, 64'h1);
        chk(irq_cnt[0] == 1, "R5 done irq", 64'(irq_cnt[0]), 64'd1);
        chk(mem[32'h100 >> 2] == 32'h0000_1000, "R4 ownership released", 64'(mem[32'h100 >> 2]), 64'h1000);

        // frame 2: R2 big-endian, offset 3; R3 decrementing
        cfg_align = 2'd3; cfg_little = 1'b0; cfg_addr_dec = 1'b1;
        expect_frame(32'h110, 32'h8000_3000, 5, 3, 1'b0, 1'b1, 8'h80, 16'h4002);
        send_frame(5, 8'h80, 16'h4002);
        drain();
        chk(mem[32'h3000 >> 2] == 32'h0000_0080, "R2 big-endian first word", 64'(mem[32'h3000 >> 2]), 64'h80);

        // frame 3: R8 oversize, then R6 null link
        cfg_align = 2'd0; cfg_little = 1'b1; cfg_addr_dec = 1'b0;
        expect_frame(32'h120, 32'h8000_2000, MAXL + 1, 0, 1'b1, 1'b0, 8'h00, 16'h4800);
        send_frame(MAXL + 1, 8'h00, 16'h4800);
        drain();
        chk(sts == 4'b1011, "R8 R6 flags after oversize frame", {60'd0, sts}, 64'hB);
        chk(irq_cnt[3] == 1, "R8 oversize irq", 64'(irq_cnt[3]), 64'd1);
        chk(irq_cnt[1] == 1, "R6 null irq", 64'(irq_cnt[1]), 64'd1);
        chk(irq_cnt[0] == 3, "R5 done irq count", 64'(irq_cnt[0]), 64'd3);
        offer_while_halted("R6 halted after null link");

        // R10 soft reset, then R7 stop policy on a CPU-owned descriptor
        mem[32'h130 >> 2] = 32'h0000_1400; mem[(32'h130 >> 2) + 3] = 32'h0;
        start_desc = 32'h130;
        cfg_skip = 1'b0;
        soft_reset();
        chk(sts == 4'd0, "R10 soft reset clears flags", {60'd0, sts}, 64'd0);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h55; rx_last = 1'b1;
        repeat (10) @(negedge clk);
        chk(sts == 4'b0100, "R7 not-owner flag (stop)", {60'd0, sts}, 64'h4);
        chk(!rx_ready, "R7 stop leaves frame unconsumed", {63'd0, rx_ready}, 64'd0);
        rx_valid = 1'b0; rx_last = 1'b0;
        chk(irq_cnt[2] == 1, "R7 not-owner irq", 64'(irq_cnt[2]), 64'd1);

        // R7 skip policy: drop, then re-check ownership on next frame
        mem[32'h140 >> 2] = 32'h0000_1800; mem[(32'h140 >> 2) + 3] = 32'h0;
        start_desc = 32'h140;
        cfg_skip = 1'b1;
        soft_reset();
        send_frame(6, 8'h40, 16'h0);
        drain();
        chk(sts == 4'b0100, "R7 skip drops frame", {60'd0, sts}, 64'h4);
        mem[32'h140 >> 2] = 32'h8000_1800;
        cfg_irq_en = 4'b1110;
        cfg_align = 2'd1; cfg_little = 1'b1; cfg_addr_dec = 1'b0;
        expect_frame(32'h140, 32'h8000_1800, 7, 1, 1'b1, 1'b0, 8'h60, 16'h4003);
        send_frame(7, 8'h60, 16'h4003);
        drain();
        chk(sts == 4'b0111, "R7 R6 flags after retried descriptor", {60'd0, sts}, 64'h7);
        chk(irq_cnt[0] == 3, "R5 masked done irq", 64'(irq_cnt[0]), 64'd3);
        chk(irq_cnt[1] == 2, "R6 null irq count", 64'(irq_cnt[1]), 64'd2);
        chk(irq_cnt[2] == 2, "R7 not-owner irq count", 64'(irq_cnt[2]), 64'd2);
        chk(exp_q.size() == 0, "R4 all expected writes seen", 64'(exp_q.size()), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule